// File: doc/BRIEF.md
# Programmable Clock Divider and Output Gate

This block produces two clock outputs from a reference clock and a synthesized (loop) clock. Both clocks arrive as levels that are already sampled in the `clk` domain. A 14-bit post-divider gives a 50% duty output at the reference rate divided by 2*P. Two cascaded source selectors build the outputs: output 0 picks the synthesized clock, the reference, or the divided reference. Output 1 picks the reference, the reference halved, output 0's source, or output 0's source halved.

One external control pin serves one of several roles, chosen by a two-bit field. It can act as an output enable, as an active-low power-down, or as a live switch between two stored configuration sets (A and B). Each set holds P and both source selects. It can also be left with no role. A low pin disables the outputs. Each output is then either released (output-enable low, modelling high impedance) or driven low, as set by its own bit. Three state machines control the block. The set selector has states SEL_A, SEL_A2B, SEL_B and SEL_B2A. Its transitions are request (A to A2B, B to B2A), withdraw (A2B to A, B2A to B) and commit, which happens on apply (A2B to B, B2A to A, or directly from A or B). One gate per output has states G_OFF and G_ON. Its transitions are open (OFF to ON) and close (ON to OFF), and both are taken only while that output's source is low.

Top module: `progclk_out`

## Requirements
- R1: The divided path has a period of 2*P reference periods and a 50% duty cycle. P = 0 behaves as P = 1.
- R2: The output 0 select is decoded as follows: 0 gives the synthesized clock, 1 gives the reference, and 2 or 3 give the divided reference.
- R3: The output 1 select is decoded as follows: 0 gives the reference, 1 gives the reference divided by 2, 2 gives output 0's source, and 3 gives output 0's source divided by 2.
- R4: With pin function 0 (enable), a low pin disables both outputs. A high pin restores them at the configured period.
- R5: Bit i of `dis_hiz` set to 1 makes a disabled output i drop its enable (`clkN_oe` = 0). Set to 0, the disabled output keeps its enable high and drives low.
- R6: With pin function 1 (power-down), a low pin stops the reference and synthesized clocks, clears the divider, and disables both outputs. After release, counting restarts from zero, so the first output 0 rise on the divided path comes about 4*P system cycles later when the reference period is 4 cycles.
- R7: With pin function 2 (select), a high pin selects set A and a low pin selects set B. A new set takes effect only at a divider terminal count, or at once during power-down.
- R8: Outputs enable and disable only while their source is low. No output high pulse is shorter than the source's high phase.
- R9: During reset both outputs are low, and an output with its `dis_hiz` bit set has its enable low.
- R10: With pin function 3, the pin has no effect, and a low pin leaves the outputs running with set A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Reference clock level |
| pll_in | input | 1 | Synthesized clock level |
| ctl_pin | input | 1 | Multi-function control pin (idles high) |
| pin_fn | input | 2 | Pin role: 0 enable, 1 power-down, 2 select, 3 none |
| cfg_a_p | input | 14 | Set A post-divider value |
| cfg_a_src0 | input | 2 | Set A output 0 source |
| cfg_a_src1 | input | 2 | Set A output 1 source |
| cfg_b_p | input | 14 | Set B post-divider value |
| cfg_b_src0 | input | 2 | Set B output 0 source |
| cfg_b_src1 | input | 2 | Set B output 1 source |
| dis_hiz | input | 2 | Per-output disabled style, 1 = release |
| clk0_out | output | 1 | Output 0 level |
| clk0_oe | output | 1 | Output 0 drive enable |
| clk1_out | output | 1 | Output 1 level |
| clk1_oe | output | 1 | Output 1 drive enable |

## Verification
The hardest case to reach is an enable or disable request that lands in the middle of a source high phase. That is the only moment a runt pulse could escape. The bench toggles the enable pin with a hold time that grows by one cycle per step, so across the sweep the request falls at every phase of both outputs. Meanwhile a monitor measures every completed high pulse against the source's high time. The same monitor watches the set switch, since a change in P between terminal counts would show up as a short pulse or a stalled divider.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
    typedef enum logic [1:0] {S0_PLL = 2'd0, S0_REF = 2'd1, S0_DIV = 2'd2, S0_DIV_ALT = 2'd3} src0_e;
    typedef enum logic [1:0] {S1_REF = 2'd0, S1_REF_HALF = 2'd1, S1_OUT0 = 2'd2, S1_OUT0_HALF = 2'd3} src1_e;
    typedef enum logic [1:0] {FN_OE = 2'd0, FN_PDN = 2'd1, FN_FSEL = 2'd2, FN_NONE = 2'd3} pinfn_e;
    typedef enum logic [1:0] {SEL_A = 2'd0, SEL_A2B = 2'd1, SEL_B = 2'd2, SEL_B2A = 2'd3} selst_e;
    typedef enum logic {G_OFF = 1'b0, G_ON = 1'b1} gate_e;
endpackage

// File: rtl/pcg_divider.sv
module pcg_divider #(
    parameter int unsigned P_W = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pdn,
    input  logic           ref_rise,
    input  logic [P_W-1:0] p_val,
    output logic           div_q,
    output logic           half_q,
    output logic           tc
);
    localparam logic [P_W-1:0] ONE = P_W'(1);

    logic [P_W-1:0] cnt;
    logic [P_W-1:0] p_eff;

    assign p_eff = (p_val == '0) ? ONE : p_val;
    assign tc    = ref_rise && (cnt == p_eff - ONE);

    always_ff @(posedge clk) begin
        if (!rst_n || pdn) begin
            cnt    <= '0;
            div_q  <= 1'b0;
            half_q <= 1'b0;
        end else if (ref_rise) begin
            half_q <= ~half_q;
            if (tc) begin
                cnt   <= '0;
                div_q <= ~div_q;
            end else begin
                cnt <= cnt + ONE;
            end
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < p_eff);                                          // R1
    AST_PDN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pdn) |-> (cnt == '0) && !div_q && !half_q);       // R6
endmodule

// File: rtl/pcg_cfgsel.sv
module pcg_cfgsel
    import pcg_pkg::*;
#(
    parameter int unsigned P_W = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           want_b,
    input  logic           apply,
    input  logic [P_W-1:0] cfg_a_p,
    input  logic [1:0]     cfg_a_s0,
    input  logic [1:0]     cfg_a_s1,
    input  logic [P_W-1:0] cfg_b_p,
    input  logic [1:0]     cfg_b_s0,
    input  logic [1:0]     cfg_b_s1,
    output logic [P_W-1:0] act_p,
    output logic [1:0]     act_s0,
    output logic [1:0]     act_s1
);
    selst_e st, st_n;
    logic   act_b, nxt_b;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= SEL_A;
        else        st <= st_n;
    end

    always_comb begin
        st_n = st;
        unique case (st)
            SEL_A:   if (want_b) st_n = apply ? SEL_B : SEL_A2B;
            SEL_A2B: if (!want_b) st_n = SEL_A;
                     else if (apply) st_n = SEL_B;
            SEL_B:   if (!want_b) st_n = apply ? SEL_A : SEL_B2A;
            SEL_B2A: if (want_b) st_n = SEL_B;
                     else if (apply) st_n = SEL_A;
            default: st_n = SEL_A;
        endcase
    end

    assign act_b = (st == SEL_B) || (st == SEL_B2A);
    assign nxt_b = (st_n == SEL_B) || (st_n == SEL_B2A);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_p  <= cfg_a_p;
            act_s0 <= cfg_a_s0;
            act_s1 <= cfg_a_s1;
        end else if (apply) begin
            act_p  <= nxt_b ? cfg_b_p  : cfg_a_p;
            act_s0 <= nxt_b ? cfg_b_s0 : cfg_a_s0;
            act_s1 <= nxt_b ? cfg_b_s1 : cfg_a_s1;
        end
    end

    AST_SET_SWITCH_ON_TC: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_b) |-> $past(apply));                      // R7
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(apply) |-> $stable(act_p));                      // R7
endmodule

// File: rtl/pcg_gate.sv
module pcg_gate
    import pcg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic src,
    input  logic hiz,
    output logic out_lvl,
    output logic out_oe
);
    gate_e st, st_n;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= G_OFF;
        else        st <= st_n;
    end

    always_comb begin
        st_n = st;
        unique case (st)
            G_OFF: if (want && !src)  st_n = G_ON;
            G_ON:  if (!want && !src) st_n = G_OFF;
            default: st_n = G_OFF;
        endcase
    end

    always_comb begin
        out_lvl = (st == G_ON) && src;
        out_oe  = (st == G_ON) || !hiz;
    end

    AST_GATE_SWITCH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st) |-> !$past(src));                          // R8
    AST_GATE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!want && !src) |-> (st == G_OFF));                // R4
endmodule

// File: rtl/progclk_out.sv
module progclk_out
    import pcg_pkg::*;
#(
    parameter int unsigned P_W = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ref_in,
    input  logic           pll_in,
    input  logic           ctl_pin,
    input  logic [1:0]     pin_fn,
    input  logic [P_W-1:0] cfg_a_p,
    input  logic [1:0]     cfg_a_src0,
    input  logic [1:0]     cfg_a_src1,
    input  logic [P_W-1:0] cfg_b_p,
    input  logic [1:0]     cfg_b_src0,
    input  logic [1:0]     cfg_b_src1,
    input  logic [1:0]     dis_hiz,
    output logic           clk0_out,
    output logic           clk0_oe,
    output logic           clk1_out,
    output logic           clk1_oe
);
    localparam int unsigned N_OUT = 2;

    // Two-stage synchronizer for the control pin; idles high.
    logic pin_s1, pin_s2;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_s1 <= 1'b1;
            pin_s2 <= 1'b1;
        end else begin
            pin_s1 <= ctl_pin;
            pin_s2 <= pin_s1;
        end
    end

    logic pdn, oe_off, want_b, want_on;
    assign pdn     = (pin_fn == FN_PDN)  && !pin_s2;
    assign oe_off  = (pin_fn == FN_OE)   && !pin_s2;
    assign want_b  = (pin_fn == FN_FSEL) && !pin_s2;
    assign want_on = !(pdn || oe_off);

    // Power-down closes the clock gates on both incoming clocks.
    logic ref_g, pll_g, ref_q, ref_rise;
    assign ref_g    = ref_in && !pdn;
    assign pll_g    = pll_in && !pdn;
    assign ref_rise = ref_g && !ref_q;

    always_ff @(posedge clk) begin
        if (!rst_n) ref_q <= 1'b0;
        else        ref_q <= ref_g;
    end

    logic [P_W-1:0] act_p;
    logic [1:0]     act_s0, act_s1;
    logic           div_q, ref_half, tc, apply;

    assign apply = tc || pdn;

    pcg_divider #(.P_W(P_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .pdn      (pdn),
        .ref_rise (ref_rise),
        .p_val    (act_p),
        .div_q    (div_q),
        .half_q   (ref_half),
        .tc       (tc)
    );

    pcg_cfgsel #(.P_W(P_W)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .want_b   (want_b),
        .apply    (apply),
        .cfg_a_p  (cfg_a_p),
        .cfg_a_s0 (cfg_a_src0),
        .cfg_a_s1 (cfg_a_src1),
        .cfg_b_p  (cfg_b_p),
        .cfg_b_s0 (cfg_b_src0),
        .cfg_b_s1 (cfg_b_src1),
        .act_p    (act_p),
        .act_s0   (act_s0),
        .act_s1   (act_s1)
    );

    // Output 0 source selector.
    logic src0_n, src0_q, s0h_q;
    always_comb begin
        case (act_s0)
            S0_PLL:  src0_n = pll_g;
            S0_REF:  src0_n = ref_g;
            default: src0_n = div_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || pdn) begin
            src0_q <= 1'b0;
            s0h_q  <= 1'b0;
        end else begin
            src0_q <= src0_n;
            if (src0_n && !src0_q) s0h_q <= ~s0h_q;
        end
    end

    // Output 1 source selector, cascaded after output 0.
    logic src1_n, src1_q;
    always_comb begin
        case (act_s1)
            S1_REF:       src1_n = ref_g;
            S1_REF_HALF:  src1_n = ref_half;
            S1_OUT0:      src1_n = src0_q;
            default:      src1_n = s0h_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || pdn) src1_q <= 1'b0;
        else               src1_q <= src1_n;
    end

    logic [N_OUT-1:0] src_v, lvl_v, oe_v;
    assign src_v = {src1_q, src0_q};

    for (genvar gi = 0; gi < N_OUT; gi++) begin : g_gate
        pcg_gate u_gate (
            .clk     (clk),
            .rst_n   (rst_n),
            .want    (want_on),
            .src     (src_v[gi]),
            .hiz     (dis_hiz[gi]),
            .out_lvl (lvl_v[gi]),
            .out_oe  (oe_v[gi])
        );
    end

    assign clk0_out = lvl_v[0];
    assign clk0_oe  = oe_v[0];
    assign clk1_out = lvl_v[1];
    assign clk1_oe  = oe_v[1];

    AST_PDN_STOPS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        pdn |-> !ref_rise && !tc);                              // R6
    AST_NONE_IGNORES_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_fn == FN_NONE) |-> want_on && !want_b);            // R10
endmodule

// File: tb/progclk_out_test.sv
module progclk_out_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_in = 1'b0;
    logic        pll_in = 1'b0;
    logic        ctl_pin = 1'b1;
    logic [1:0]  pin_fn = 2'd0;
    logic [13:0] cfg_a_p = 14'd1;
    logic [1:0]  cfg_a_src0 = 2'd1;
    logic [1:0]  cfg_a_src1 = 2'd0;
    logic [13:0] cfg_b_p = 14'd1;
    logic [1:0]  cfg_b_src0 = 2'd1;
    logic [1:0]  cfg_b_src1 = 2'd0;
    logic [1:0]  dis_hiz = 2'b11;
    logic        clk0_out, clk0_oe, clk1_out, clk1_oe;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    progclk_out uut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .pll_in(pll_in),
        .ctl_pin(ctl_pin), .pin_fn(pin_fn),
        .cfg_a_p(cfg_a_p), .cfg_a_src0(cfg_a_src0), .cfg_a_src1(cfg_a_src1),
        .cfg_b_p(cfg_b_p), .cfg_b_src0(cfg_b_src0), .cfg_b_src1(cfg_b_src1),
        .dis_hiz(dis_hiz),
        .clk0_out(clk0_out), .clk0_oe(clk0_oe), .clk1_out(clk1_out), .clk1_oe(clk1_oe)
    );

    // Reference: period 4 cycles. Synthesized clock: period 6 cycles.
    int rdiv = 0;
    int pdiv = 0;
    always @(negedge clk) begin
        if (rdiv == 1) begin rdiv <= 0; ref_in <= ~ref_in; end
        else rdiv <= rdiv + 1;
        if (pdiv == 2) begin pdiv <= 0; pll_in <= ~pll_in; end
        else pdiv <= pdiv + 1;
    end

    // Runt monitor (R8): every completed high pulse must be at least min_hi long.
    logic mon_en = 1'b0;
    int   min0 = 0, min1 = 0;
    int   run0 = 0, run1 = 0, runts0 = 0, runts1 = 0;
    logic seen0 = 1'b0, seen1 = 1'b0, prev0 = 1'b0, prev1 = 1'b0;
    always @(negedge clk) begin
        if (!mon_en) begin
            seen0 <= 1'b0; seen1 <= 1'b0; run0 <= 0; run1 <= 0;
        end else begin
            if (clk0_out && !prev0) begin seen0 <= 1'b1; run0 <= 1; end
            else if (clk0_out) run0 <= run0 + 1;
            else if (prev0 && seen0 && run0 < min0) runts0 <= runts0 + 1;
            if (clk1_out && !prev1) begin seen1 <= 1'b1; run1 <= 1; end
            else if (clk1_out) run1 <= run1 + 1;
            else if (prev1 && seen1 && run1 < min1) runts1 <= runts1 + 1;
        end
        prev0 <= clk0_out;
        prev1 <= clk1_out;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic lvl(input int which);
        return (which == 0) ? clk0_out : clk1_out;
    endfunction

    // Period and high time between two consecutive rises; -1 on timeout.
    task automatic measure(input int which, output int per, output int hi);
        logic prev, c;
        int   guard;
        per = -1; hi = -1;
        prev = lvl(which);
        guard = 0;
        do begin
            @(negedge clk); c = lvl(which); guard++;
            if (c && !prev) break;
            prev = c;
        end while (guard < 3000);
        if (guard >= 3000) return;
        hi = 1; per = 0; prev = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk); per++; c = lvl(which);
            if (c && !prev) return;
            if (c) hi++;
            prev = c;
        end
        per = -1;
    endtask

    function automatic int exp_t0(input int s0, input int p);
        int pe;
        pe = (p == 0) ? 1 : p;
        if (s0 == 0) return 6;
        if (s0 == 1) return 4;
        return 8 * pe;
    endfunction

    function automatic int exp_t1(input int s1, input int t0);
        if (s1 == 0) return 4;
        if (s1 == 1) return 8;
        if (s1 == 2) return t0;
        return 2 * t0;
    endfunction

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        int per, hi, t0, t1, highs, lat;
        // R9: reset state.
        repeat (3) @(negedge clk);
        chk("R9 clk0_out in reset", clk0_out, 0);
        chk("R9 clk1_out in reset", clk1_out, 0);
        chk("R9 clk0_oe in reset", clk0_oe, 0);
        chk("R9 clk1_oe in reset", clk1_oe, 0);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1, R2, R3: sweep P, both selects.
        for (int p = 0; p <= 4; p++) begin
            for (int s0 = 0; s0 < 4; s0++) begin
                for (int s1 = 0; s1 < 4; s1++) begin
                    cfg_a_p = 14'(p); cfg_a_src0 = 2'(s0); cfg_a_src1 = 2'(s1);
                    repeat (120) @(negedge clk);
                    t0 = exp_t0(s0, p);
                    t1 = exp_t1(s1, t0);
                    measure(0, per, hi);
                    chk($sformatf("R2 R1 out0 period p=%0d s0=%0d", p, s0), per, t0);
                    chk($sformatf("R1 out0 high p=%0d s0=%0d", p, s0), hi, t0 / 2);
                    measure(1, per, hi);
                    chk($sformatf("R3 out1 period s0=%0d s1=%0d p=%0d", s0, s1, p), per, t1);
                    chk($sformatf("R3 out1 high s0=%0d s1=%0d p=%0d", s0, s1, p), hi, t1 / 2);
                end
            end
        end

        // R4, R5: enable function with both disabled styles.
        pin_fn = 2'd0; cfg_a_p = 14'd2; cfg_a_src0 = 2'd2; cfg_a_src1 = 2'd0;
        dis_hiz = 2'b10;
        repeat (100) @(negedge clk);
        ctl_pin = 1'b0;
        repeat (40) @(negedge clk);
        highs = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); highs += int'(clk0_out) + int'(clk1_out);
        end
        chk("R4 outputs held low while disabled", highs, 0);
        chk("R5 out0 driven low keeps oe", clk0_oe, 1);
        chk("R5 out1 released drops oe", clk1_oe, 0);
        dis_hiz = 2'b01;
        @(negedge clk);
        chk("R5 out0 released drops oe", clk0_oe, 0);
        chk("R5 out1 driven low keeps oe", clk1_oe, 1);
        ctl_pin = 1'b1;
        repeat (40) @(negedge clk);
        chk("R4 out0 oe restored", clk0_oe, 1);
        chk("R4 out1 oe restored", clk1_oe, 1);
        measure(0, per, hi);
        chk("R4 out0 period after enable", per, 16);

        // R8: enable toggled at every phase; no runt pulses.
        cfg_a_p = 14'd3; cfg_a_src0 = 2'd2; cfg_a_src1 = 2'd3;
        repeat (150) @(negedge clk);
        min0 = 12; min1 = 24; runts0 = 0; runts1 = 0; mon_en = 1'b1;
        for (int k = 0; k < 24; k++) begin
            ctl_pin = 1'b0;
            repeat (5 + k) @(negedge clk);
            ctl_pin = 1'b1;
            repeat (9 + 2 * k) @(negedge clk);
        end
        repeat (100) @(negedge clk);
        mon_en = 1'b0;
        chk("R8 runt pulses on out0", runts0, 0);
        chk("R8 runt pulses on out1", runts1, 0);

        // R7: select function, set A high pin, set B low pin.
        pin_fn = 2'd2;
        cfg_a_p = 14'd1; cfg_a_src0 = 2'd2; cfg_a_src1 = 2'd0;
        cfg_b_p = 14'd3; cfg_b_src0 = 2'd2; cfg_b_src1 = 2'd1;
        repeat (100) @(negedge clk);
        measure(0, per, hi);
        chk("R7 set A out0 period", per, 8);
        measure(1, per, hi);
        chk("R7 set A out1 period", per, 4);
        min0 = 4; min1 = 0; runts0 = 0; mon_en = 1'b1;
        ctl_pin = 1'b0;
        repeat (100) @(negedge clk);
        measure(0, per, hi);
        chk("R7 set B out0 period", per, 24);
        measure(1, per, hi);
        chk("R7 set B out1 period", per, 8);
        for (int k = 0; k < 10; k++) begin
            ctl_pin = ~ctl_pin;
            repeat (7 + 3 * k) @(negedge clk);
        end
        ctl_pin = 1'b1;
        repeat (100) @(negedge clk);
        mon_en = 1'b0;
        chk("R7 R8 runts across set switches", runts0, 0);
        measure(0, per, hi);
        chk("R7 back to set A out0 period", per, 8);

        // R6: power-down clears counting; restart from zero.
        pin_fn = 2'd1; dis_hiz = 2'b01;
        cfg_a_p = 14'd5; cfg_a_src0 = 2'd2; cfg_a_src1 = 2'd0;
        repeat (120) @(negedge clk);
        ctl_pin = 1'b0;
        repeat (20) @(negedge clk);
        highs = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); highs += int'(clk0_out) + int'(clk1_out);
        end
        chk("R6 outputs low in power-down", highs, 0);
        chk("R6 R5 out0 released", clk0_oe, 0);
        chk("R6 R5 out1 driven low", clk1_oe, 1);
        ctl_pin = 1'b1;
        lat = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk); lat++;
            if (clk0_out) break;
        end
        chk("R6 first rise after release in window", int'(lat >= 18 && lat <= 25), 1);
        measure(0, per, hi);
        chk("R6 out0 period after release", per, 40);

        // R10: no pin role; low pin is ignored.
        pin_fn = 2'd3; cfg_a_p = 14'd2; cfg_a_src0 = 2'd2; cfg_a_src1 = 2'd3;
        ctl_pin = 1'b0;
        repeat (120) @(negedge clk);
        measure(0, per, hi);
        chk("R10 out0 runs with pin low", per, 16);
        measure(1, per, hi);
        chk("R10 out1 runs with pin low", per, 32);
        chk("R10 out0 oe with pin low", clk0_oe, 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule